// File: doc/BRIEF.md
# Hiccup-Protected Fixed-Frequency PWM Controller

This block drives the gate of the power switch in a peak-current-mode converter. It produces one pulse per switching period. The period comes from a divided system clock, at one of four selectable rates. The pulse width comes from a digital duty word, and it is limited by an 80% ceiling and by a soft-start ramp that opens gradually after each start. An external comparator reports peak current as a single flag. When that flag is seen during a pulse, the pulse ends in the next clock cycle.

A long run of current-limited periods is treated as a short circuit. The gate is then held off for a fixed number of switching periods, and the block restarts with a fresh soft-start ramp. This off-and-retry loop repeats for as long as the fault remains. The power-path logic gates the whole block through an enable: this input is high in the powered-on state or in local-power mode, and dropping it stops switching at once.

Top module: `hiccup_pwm`

## Requirements
- R1: The switching period is CLK_KHZ/f clock cycles. The selector encodes f as follows: freqSel 0 = 100 kHz, 1 = 225 kHz, 2 = 350 kHz, 3 = 500 kHz.
- R2: The gate rises on the first cycle of a period and stays high for floor(dutyCmd*P/2^DUTY_W) cycles, where P is the period length. A duty word of 0 gives no pulse.
- R3: The pulse never exceeds floor(4*P/5) cycles, whatever the duty word.
- R4: If limitFlag is sampled high on a clock edge while the gate is high, the gate is low from that edge on and stays low for the rest of the period.
- R5: The duty word and the frequency selector are taken only at a period boundary. A change in the middle of a pulse does not alter that pulse.
- R6: Every start (enable, or restart after a hiccup) begins a ramp. In period k after the start (k = 0 .. SS_PERIODS-1), the pulse cap is floor(floor(4P/5)*(k+1)/SS_PERIODS). From period SS_PERIODS-1 onward, the cap is the full 80% ceiling.
- R7: A period counts as current-limited if the pulse was cut in it. When 32 periods in a row are current-limited, the gate stays low for the next 256 switching periods. Switching then restarts on its own, and the cycle repeats indefinitely.
- R8: Any period that is not current-limited clears the count of consecutive limited periods.
- R9: With enable low, the gate is low from the next clock edge onward. This also cancels a hiccup wait. Raising enable starts the first pulse on the next clock edge.
- R10: During and after an active-low reset, with enable low, the gate is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Switching permitted (powered on or local power) |
| freqSel | input | 2 | Switching frequency select |
| dutyCmd | input | DUTY_W | Requested on-time as a fraction of 2^DUTY_W |
| limitFlag | input | 1 | Peak-current comparator flag, sampled every clock |
| gateOut | output | 1 | Gate drive for the power switch |

## Verification
On every cycle, the assertions check four things: the gate stays under the 80% ceiling within the current period, a sampled limit flag ends the pulse, the latched period settings hold between boundaries, and the fault counters clear, trip and release at the right moments. The exact widths and spacings can only be shown by the bench scenarios. These cover the ramp sequence after each start, the 5140-cycle gap between the last limited pulse and the restart, recovery once the fault clears, and a single clean period breaking a run of limited ones. The bench scenarios also show that a duty change in mid-pulse is deferred, and that dropping enable during a hiccup leads to an immediate restart.

// File: rtl/hiccup_pwm_pkg.sv
package hiccup_pwm_pkg;

  localparam int unsigned FREQ_SEL_W = 2;

  // Switching rate in kHz for each selector code.
  function automatic int unsigned freqKhz(input int unsigned idx);
    case (idx)
      0:       return 100;
      1:       return 225;
      2:       return 350;
      default: return 500;
    endcase
  endfunction

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_RUN    = 2'd1,
    ST_HICCUP = 2'd2
  } pwmState_e;

  // Control -> datapath strobes
  typedef struct packed {
    logic runCount;   // period counter advances
    logic gateEn;     // pulses may reach the gate
    logic rampClear;  // hold soft-start at its first step
  } ctrlStrobe_t;

  // Datapath -> control per-period status
  typedef struct packed {
    logic periodEnd;  // last cycle of a period
    logic limited;    // this period had a cut pulse
  } cycleStatus_t;

endpackage

// File: rtl/hiccup_pwm_datapath.sv
module hiccup_pwm_datapath
  import hiccup_pwm_pkg::*;
#(
  parameter int unsigned CLK_KHZ    = 50000,
  parameter int unsigned DUTY_W     = 8,
  parameter int unsigned SS_PERIODS = 16,
  parameter int unsigned CAP_NUM    = 4,
  parameter int unsigned CAP_DEN    = 5
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [FREQ_SEL_W-1:0] freqSel,
  input  logic [DUTY_W-1:0]     dutyCmd,
  input  logic                  limitFlag,
  input  ctrlStrobe_t           strobe,
  output cycleStatus_t          status,
  output logic                  gateOut
);

  localparam int unsigned PER_MAX  = CLK_KHZ / freqKhz(0);
  localparam int unsigned PER_W    = $clog2(PER_MAX + 1);
  localparam int unsigned RAMP_W   = (SS_PERIODS > 1) ? $clog2(SS_PERIODS) : 1;
  localparam int unsigned PROD_W   = PER_W + RAMP_W + 1;
  localparam int unsigned DP_W     = PER_W + DUTY_W;
  localparam int unsigned N_FREQ   = 1 << FREQ_SEL_W;
  localparam logic [RAMP_W-1:0] RAMP_TOP = RAMP_W'(SS_PERIODS - 1);

  logic [PER_W-1:0]  perChoice   [N_FREQ];
  logic [PER_W-1:0]  maxOnChoice [N_FREQ];
  logic [PER_W-1:0]  perNext, maxOnNext, dutyOn, capOn, onNext;
  logic [PER_W-1:0]  cnt, perLenQ, onLenQ;
  logic              cut;
  logic [RAMP_W-1:0] rampIdx, rampNext;
  logic [RAMP_W:0]   rampPlus;
  logic [PROD_W-1:0] capProd;
  logic [DP_W-1:0]   dutyProd;
  logic              periodEnd, loadNow;

  // Period length and 80% ceiling per selector code, fixed at elaboration
  for (genvar g = 0; g < N_FREQ; g++) begin : g_freq
    localparam int unsigned LEN = CLK_KHZ / freqKhz(g);
    assign perChoice[g]   = PER_W'(LEN);
    assign maxOnChoice[g] = PER_W'((LEN * CAP_NUM) / CAP_DEN);
  end

  assign perNext   = perChoice[freqSel];
  assign maxOnNext = maxOnChoice[freqSel];

  assign periodEnd = strobe.runCount && (cnt == perLenQ - PER_W'(1));
  assign loadNow   = !strobe.runCount || periodEnd;

  // Ramp index for the period that is about to be loaded
  always_comb begin
    if (strobe.rampClear)
      rampNext = '0;
    else if (periodEnd && (rampIdx != RAMP_TOP))
      rampNext = rampIdx + RAMP_W'(1);
    else
      rampNext = rampIdx;
  end

  assign rampPlus = {1'b0, rampNext} + (RAMP_W + 1)'(1);
  assign capProd  = PROD_W'(maxOnNext) * PROD_W'(rampPlus);

  if ((SS_PERIODS & (SS_PERIODS - 1)) == 0) begin : g_capShift
    assign capOn = PER_W'(capProd >> $clog2(SS_PERIODS));
  end else begin : g_capDiv
    assign capOn = PER_W'(capProd / PROD_W'(SS_PERIODS));
  end

  assign dutyProd = DP_W'(dutyCmd) * DP_W'(perNext);
  assign dutyOn   = PER_W'(dutyProd >> DUTY_W);
  assign onNext   = (dutyOn < capOn) ? dutyOn : capOn;

  assign gateOut = strobe.gateEn && (cnt < onLenQ) && !cut;

  assign status.periodEnd = periodEnd;
  assign status.limited   = cut || (gateOut && limitFlag);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt     <= '0;
      perLenQ <= '0;
      onLenQ  <= '0;
      cut     <= 1'b0;
      rampIdx <= '0;
    end else begin
      rampIdx <= rampNext;
      if (loadNow) begin
        cnt     <= '0;
        perLenQ <= perNext;
        onLenQ  <= onNext;
        cut     <= 1'b0;
      end else begin
        cnt <= cnt + PER_W'(1);
        if (gateOut && limitFlag)
          cut <= 1'b1;
      end
    end
  end

  // R3
  gate_cap_chk: assert property (@(posedge clk) disable iff (!rstN)
    gateOut |-> ((32'(cnt) * CAP_DEN) < (32'(perLenQ) * CAP_NUM)));

  // R4
  cut_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (gateOut && limitFlag && !periodEnd) |=> !gateOut);

  // R5
  load_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.runCount && !periodEnd) |=> ($stable(onLenQ) && $stable(perLenQ)));

  // R6
  ramp_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.rampClear && strobe.runCount) |=> (rampIdx >= $past(rampIdx)));

endmodule

// File: rtl/hiccup_pwm_control.sv
module hiccup_pwm_control
  import hiccup_pwm_pkg::*;
#(
  parameter int unsigned LIMIT_RUN   = 32,
  parameter int unsigned OFF_PERIODS = 256
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         enable,
  input  cycleStatus_t status,
  output ctrlStrobe_t  strobe
);

  localparam int unsigned LIM_W = (LIMIT_RUN > 1) ? $clog2(LIMIT_RUN) : 1;
  localparam int unsigned OFF_W = (OFF_PERIODS > 1) ? $clog2(OFF_PERIODS) : 1;
  localparam logic [LIM_W-1:0] LIM_LAST = LIM_W'(LIMIT_RUN - 1);
  localparam logic [OFF_W-1:0] OFF_LAST = OFF_W'(OFF_PERIODS - 1);

  pwmState_e        state;
  logic [LIM_W-1:0] limCnt;
  logic [OFF_W-1:0] offCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      limCnt <= '0;
      offCnt <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          limCnt <= '0;
          offCnt <= '0;
          if (enable)
            state <= ST_RUN;
        end
        ST_RUN: begin
          if (!enable) begin
            state <= ST_IDLE;
          end else if (status.periodEnd) begin
            if (status.limited) begin
              if (limCnt == LIM_LAST) begin
                state  <= ST_HICCUP;
                limCnt <= '0;
                offCnt <= '0;
              end else begin
                limCnt <= limCnt + LIM_W'(1);
              end
            end else begin
              limCnt <= '0;
            end
          end
        end
        ST_HICCUP: begin
          if (!enable) begin
            state <= ST_IDLE;
          end else if (status.periodEnd) begin
            if (offCnt == OFF_LAST)
              state <= ST_RUN;
            else
              offCnt <= offCnt + OFF_W'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe.runCount  = (state != ST_IDLE);
    strobe.gateEn    = (state == ST_RUN);
    strobe.rampClear = (state != ST_RUN);
  end

  // R8
  run_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN && enable && status.periodEnd && !status.limited) |=> (limCnt == '0));

  // R7
  trip_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(state == ST_HICCUP) |-> ($past(limCnt) == LIM_LAST && $past(status.limited)));

  // R7
  restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_HICCUP && enable && status.periodEnd && offCnt == OFF_LAST) |=> (state == ST_RUN));

  // R9
  disable_chk: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (state == ST_IDLE));

endmodule

// File: rtl/hiccup_pwm.sv
module hiccup_pwm
  import hiccup_pwm_pkg::*;
#(
  parameter int unsigned CLK_KHZ     = 50000,
  parameter int unsigned DUTY_W      = 8,
  parameter int unsigned SS_PERIODS  = 16,
  parameter int unsigned LIMIT_RUN   = 32,
  parameter int unsigned OFF_PERIODS = 256
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic [1:0]        freqSel,
  input  logic [DUTY_W-1:0] dutyCmd,
  input  logic              limitFlag,
  output logic              gateOut
);

  ctrlStrobe_t  strobe;
  cycleStatus_t status;

  hiccup_pwm_control #(
    .LIMIT_RUN  (LIMIT_RUN),
    .OFF_PERIODS(OFF_PERIODS)
  ) u_control (
    .clk   (clk),
    .rstN  (rstN),
    .enable(enable),
    .status(status),
    .strobe(strobe)
  );

  hiccup_pwm_datapath #(
    .CLK_KHZ   (CLK_KHZ),
    .DUTY_W    (DUTY_W),
    .SS_PERIODS(SS_PERIODS)
  ) u_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .freqSel  (freqSel),
    .dutyCmd  (dutyCmd),
    .limitFlag(limitFlag),
    .strobe   (strobe),
    .status   (status),
    .gateOut  (gateOut)
  );

  // R10
  reset_gate_chk: assert property (@(posedge clk)
    !rstN |-> !gateOut);

endmodule

// File: tb/hiccup_pwm_test.sv
`timescale 1ns/1ps
module hiccup_pwm_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       enable = 1'b0;
  logic       limitFlag = 1'b0;
  logic [1:0] freqSel = 2'd3;
  logic [7:0] dutyCmd = 8'd0;
  logic       gateOut;

  int     errors = 0;
  int     checks = 0;
  longint cycNow = 0;
  bit     finished = 1'b0;

  int     hiLen [72];
  longint riseAt [72];
  bit     faultMask [72];

  typedef struct packed {
    logic [1:0] fs;
    logic [7:0] duty;
    logic [7:0] expOn;
    logic [7:0] expPer;
  } vec_t;

  // CLK_KHZ = 10000: periods 100 / 44 / 28 / 20, ceilings 80 / 35 / 22 / 16
  localparam vec_t VECS [8] = '{
    '{2'd3, 8'd128, 8'd10, 8'd20},
    '{2'd3, 8'd255, 8'd16, 8'd20},
    '{2'd0, 8'd64,  8'd25, 8'd100},
    '{2'd0, 8'd250, 8'd80, 8'd100},
    '{2'd1, 8'd100, 8'd17, 8'd44},
    '{2'd2, 8'd200, 8'd21, 8'd28},
    '{2'd2, 8'd230, 8'd22, 8'd28},
    '{2'd1, 8'd255, 8'd35, 8'd44}
  };

  hiccup_pwm #(
    .CLK_KHZ   (10000),
    .DUTY_W    (8),
    .SS_PERIODS(4)
  ) uut (
    .clk      (clk),
    .rstN     (rstN),
    .enable   (enable),
    .freqSel  (freqSel),
    .dutyCmd  (dutyCmd),
    .limitFlag(limitFlag),
    .gateOut  (gateOut)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cycNow <= cycNow + 1;

  task automatic checkEq(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Called at a negedge. Records n pulses, applying faultMask[i] before pulse i.
  task automatic capturePulses(input int n);
    int waitCnt;
    while (gateOut) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      limitFlag = faultMask[i];
      waitCnt = 0;
      while (!gateOut && waitCnt < 20000) begin
        @(negedge clk);
        waitCnt++;
      end
      if (waitCnt >= 20000) begin
        for (int j = i; j < n; j++) begin
          hiLen[j] = -1;
          riseAt[j] = -1;
        end
        break;
      end
      riseAt[i] = cycNow;
      hiLen[i] = 0;
      while (gateOut) begin
        hiLen[i]++;
        @(negedge clk);
      end
    end
    limitFlag = 1'b0;
  endtask

  task automatic clearMask();
    for (int i = 0; i < 72; i++) faultMask[i] = 1'b0;
  endtask

  task automatic countHigh(input int n, output int highs);
    highs = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (gateOut) highs++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int highs;
    int hi;
    longint tMark;
    longint maxGap;

    clearMask();
    // R10: reset
    repeat (3) @(negedge clk);
    checkEq("R10", "gate during reset", gateOut, 0);
    rstN = 1'b1;
    dutyCmd = 8'd255;
    freqSel = 2'd3;
    countHigh(50, highs);
    checkEq("R10", "gate high cycles after reset, enable low", highs, 0);

    // R6 and R9: start and soft-start ramp
    enable = 1'b1;
    tMark = cycNow;
    capturePulses(6);
    checkEq("R9", "first rise delay after enable", riseAt[0] - tMark, 1);
    checkEq("R6", "ramp pulse 0", hiLen[0], 4);
    checkEq("R6", "ramp pulse 1", hiLen[1], 8);
    checkEq("R6", "ramp pulse 2", hiLen[2], 12);
    checkEq("R6", "ramp pulse 3", hiLen[3], 16);
    checkEq("R6", "ramp pulse 5", hiLen[5], 16);
    checkEq("R1", "period during ramp", riseAt[5] - riseAt[4], 20);

    // R1, R2, R3: vector table
    for (int v = 0; v < 8; v++) begin
      freqSel = VECS[v].fs;
      dutyCmd = VECS[v].duty;
      capturePulses(3);
      checkEq("R2", $sformatf("vector %0d on-time (R3 cap)", v), hiLen[2], longint'(VECS[v].expOn));
      checkEq("R1", $sformatf("vector %0d period", v), riseAt[2] - riseAt[1], longint'(VECS[v].expPer));
    end

    // R5: duty change during a pulse is deferred
    freqSel = 2'd0;
    dutyCmd = 8'd64;
    capturePulses(2);
    while (!gateOut) @(negedge clk);
    hi = 0;
    while (gateOut) begin
      hi++;
      if (hi == 3) dutyCmd = 8'd250;
      @(negedge clk);
    end
    checkEq("R5", "pulse with mid-pulse duty change", hi, 25);
    capturePulses(1);
    checkEq("R5", "next pulse uses new duty", hiLen[0], 80);
    dutyCmd = 8'd64;
    capturePulses(2);

    // R4: cycle-by-cycle cut
    while (!gateOut) @(negedge clk);
    hi = 1;
    while (hi < 5) begin
      @(negedge clk);
      if (gateOut) hi++;
    end
    limitFlag = 1'b1;
    @(negedge clk);
    limitFlag = 1'b0;
    checkEq("R4", "gate after limit flag", gateOut, 0);
    countHigh(20, highs);
    checkEq("R4", "gate stays low rest of period", highs, 0);
    capturePulses(2);
    checkEq("R4", "following period full width", hiLen[1], 25);

    // R8: a clean period breaks the limited run
    freqSel = 2'd3;
    dutyCmd = 8'd128;
    capturePulses(3);
    clearMask();
    for (int i = 0; i < 31; i++) faultMask[i] = 1'b1;
    for (int i = 32; i < 63; i++) faultMask[i] = 1'b1;
    capturePulses(64);
    maxGap = 0;
    for (int i = 1; i < 64; i++)
      if (riseAt[i] - riseAt[i-1] > maxGap) maxGap = riseAt[i] - riseAt[i-1];
    checkEq("R8", "limited pulse width", hiLen[0], 1);
    checkEq("R8", "clean pulse width", hiLen[31], 10);
    checkEq("R8", "largest gap (no hiccup)", maxGap, 20);

    // R7: 32 limited periods -> 256 periods off -> restart with ramp
    clearMask();
    for (int i = 0; i < 33; i++) faultMask[i] = 1'b1;
    capturePulses(36);
    checkEq("R7", "limited pulse width", hiLen[0], 1);
    checkEq("R7", "gap before 32nd limited pulse", riseAt[31] - riseAt[30], 20);
    checkEq("R7", "gap over hiccup", riseAt[32] - riseAt[31], 5140);
    checkEq("R7", "first pulse after restart", hiLen[32], 1);
    checkEq("R7", "recovery pulse (R6 step 1)", hiLen[33], 8);
    checkEq("R7", "recovery pulse step 2", hiLen[34], 10);
    checkEq("R7", "recovery period", riseAt[35] - riseAt[34], 20);
    clearMask();

    // R9: enable drop while switching, ramp restarts
    capturePulses(2);
    while (!gateOut) @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    checkEq("R9", "gate after enable drop", gateOut, 0);
    countHigh(100, highs);
    checkEq("R9", "gate high cycles while disabled", highs, 0);
    enable = 1'b1;
    capturePulses(3);
    checkEq("R6", "re-enable ramp pulse 0", hiLen[0], 4);
    checkEq("R6", "re-enable ramp pulse 1", hiLen[1], 8);
    checkEq("R6", "re-enable ramp pulse 2", hiLen[2], 10);

    // R9: enable cycling cancels a hiccup wait
    capturePulses(2);
    for (int i = 0; i < 32; i++) faultMask[i] = 1'b1;
    capturePulses(32);
    clearMask();
    countHigh(100, highs);
    checkEq("R7", "gate high cycles during hiccup", highs, 0);
    enable = 1'b0;
    @(negedge clk);
    enable = 1'b1;
    tMark = cycNow;
    capturePulses(1);
    checkEq("R9", "restart delay after enable cycle", riseAt[0] - tMark, 1);
    checkEq("R9", "restart pulse width", hiLen[0], 4);

    // R2: zero duty gives no pulse
    dutyCmd = 8'd0;
    repeat (60) @(negedge clk);
    countHigh(100, highs);
    checkEq("R2", "gate high cycles at duty 0", highs, 0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule